// File: doc/BRIEF.md
# Load/Store Multiple Sequencer

This block executes one load-multiple or store-multiple command as a series of single memory accesses. A command supplies a base address, a five-bit register-selection field, a direction (load or store) and an access size of four or eight bytes. The sequencer works out which architectural registers the field selects. It issues one memory request per register over a plain request/ready channel and moves the address along by the access size after each transfer.

Loads wait for the response data. The data is written into the register file, and word-sized data is sign-extended to the register width. Stores read the selected register combinationally and present its value as write data. The low four bits of the field give a count of registers, taken from a fixed, non-contiguous table. The top bit adds one more transfer for the link register. A one-cycle completion pulse ends each command. A busy flag keeps new commands out while a sequence runs.

Top module: `lsm_sequencer`

## Requirements
- R1: When `cmdList[3:0]` holds a count N from 1 to 9, the sequencer makes N table transfers. The registers are taken in this order: 16, 17, 18, 19, 20, 21, 22, 23, 30.
- R2: When `cmdList[3:0]` is 0 or lies in 10..15, no table transfer takes place.
- R3: When `cmdList[4]` is 1, exactly one extra transfer for register 31 follows the table transfers.
- R4: Transfer k (from 0) uses address `cmdBase + k*S`, where S is 4 when `cmdDouble` is 0 and 8 when it is 1. This holds for the register-31 transfer too. `memSize` equals `cmdDouble` (1 means eight bytes).
- R5: A load writes the register file for one cycle, in the cycle `memRvalid` is high. The write goes to the transfer's register. The data is `memRdata` sign-extended from bit 31 for word size, and `memRdata` unchanged for doubleword size.
- R6: A store drives `memWrite` high, names the transfer's register on `rfRaddr` and forwards `rfRdata` on `memWdata` in the same cycle. Loads drive `memWrite` low.
- R7: At most one access is outstanding at a time. `memReq` stays high with a stable address until `memReady` is seen. After an accepted load, no new request is made until `memRvalid` arrives.
- R8: `done` is high for exactly one cycle, in the cycle after the final transfer completes. When nothing is selected, `done` is high in the cycle right after the command is accepted.
- R9: A command is accepted only while `busy` is low. `busy` stays high from the cycle after acceptance through the `done` cycle. `cmdValid` while busy has no effect.
- R10: While reset (`rstN` low) is asserted, `busy`, `done`, `memReq` and `rfWe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command present; taken when busy is low |
| cmdLoad | input | 1 | 1 = load-multiple, 0 = store-multiple |
| cmdDouble | input | 1 | 1 = eight-byte accesses, 0 = four-byte |
| cmdBase | input | ADDR_W | Address of the first transfer |
| cmdList | input | 5 | [3:0] table count, [4] link-register transfer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| memReq | output | 1 | Memory request valid |
| memWrite | output | 1 | 1 = write access |
| memSize | output | 1 | 1 = eight bytes, 0 = four bytes |
| memAddr | output | ADDR_W | Access address |
| memWdata | output | XLEN | Store data |
| memReady | input | 1 | Request accepted this cycle |
| memRvalid | input | 1 | Load data valid this cycle |
| memRdata | input | XLEN | Load data |
| rfRaddr | output | 5 | Register read index (stores) |
| rfRdata | input | XLEN | Register read data |
| rfWe | output | 1 | Register write enable (loads) |
| rfWaddr | output | 5 | Register write index |
| rfWdata | output | XLEN | Register write data |

## Verification
The assertions check the following on every cycle:
- `done` never lasts two cycles and is always followed by idle.
- A stalled request holds its address and direction.
- Requests appear only while busy.
- Each store moves the next address on by exactly the access size.
- A register write comes only with response data, and only to register 16..23, 30 or 31.

Some behaviour only the bench's sweep can show:
- the exact register order for every field value;
- the count that the out-of-range values drop;
- the sign extension of word loads;
- the timing of `done` for empty commands;
- that a command offered mid-sequence leaves the running one untouched.

The sweep runs over both directions, both sizes and all 32 field values, under pseudo-random ready and response stalls.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  localparam int REG_W    = 5;
  localparam int TBL_FIRST = 16;  // first of the contiguous run
  localparam int TBL_RUN   = 8;   // length of the contiguous run
  localparam int TBL_TAIL  = 30;  // entry after the run
  localparam int TBL_LEN   = TBL_RUN + 1;
  localparam int LINK_REG  = 31;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_FIN
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch a new command
    logic step;     // one transfer finished, move on
    logic wrback;   // load data arrives, write register file
  } seqStrobe_t;

  // number of table transfers a list field selects
  function automatic logic [3:0] tableCount(input logic [4:0] list);
    logic [3:0] n;
    n = list[3:0];
    return (n != 4'd0 && int'(n) <= TBL_LEN) ? n : 4'd0;
  endfunction

  // register index held in table position slot
  function automatic logic [REG_W-1:0] tableReg(input logic [3:0] slot);
    return (int'(slot) < TBL_RUN) ? REG_W'(TBL_FIRST + int'(slot)) : REG_W'(TBL_TAIL);
  endfunction

endpackage

// File: rtl/lsm_ctrl.sv
module lsm_ctrl
  import lsm_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [4:0]       cmdList,
  input  logic             memReady,
  input  logic             memRvalid,
  input  logic             modeLoad,
  output logic             busy,
  output logic             done,
  output logic             memReq,
  output logic [CNT_W-1:0] slot,
  output seqStrobe_t       strb
);

  seqState_t        stateQ, stateD;
  logic [CNT_W-1:0] slotQ, lastQ;
  logic [CNT_W-1:0] total;
  logic             accept, isLast;

  assign total  = CNT_W'(tableCount(cmdList)) + CNT_W'(cmdList[4]);
  assign accept = cmdValid && (stateQ == ST_IDLE);
  assign isLast = (slotQ == lastQ);

  always_comb begin
    strb.capture = accept;
    strb.wrback  = (stateQ == ST_WAIT) && memRvalid;
    strb.step    = ((stateQ == ST_REQ) && memReady && !modeLoad) || strb.wrback;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (accept) stateD = (total == '0) ? ST_FIN : ST_REQ;
      ST_REQ: begin
        if (memReady) begin
          if (modeLoad)    stateD = ST_WAIT;
          else if (isLast) stateD = ST_FIN;
          else             stateD = ST_REQ;
        end
      end
      ST_WAIT: if (memRvalid) stateD = isLast ? ST_FIN : ST_REQ;
      ST_FIN:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      slotQ  <= '0;
      lastQ  <= '0;
    end else begin
      stateQ <= stateD;
      if (strb.capture) begin
        slotQ <= '0;
        lastQ <= total - CNT_W'(1);
      end else if (strb.step) begin
        slotQ <= slotQ + CNT_W'(1);
      end
    end
  end

  assign busy   = (stateQ != ST_IDLE);
  assign done   = (stateQ == ST_FIN);
  assign memReq = (stateQ == ST_REQ);
  assign slot   = slotQ;

endmodule

// File: rtl/lsm_datapath.sv
module lsm_datapath
  import lsm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int XLEN   = 64,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [CNT_W-1:0]  slot,
  input  logic              cmdLoad,
  input  logic              cmdDouble,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic [4:0]        cmdList,
  input  logic [XLEN-1:0]   memRdata,
  input  logic [XLEN-1:0]   rfRdata,
  output logic              modeLoad,
  output logic              memWrite,
  output logic              memSize,
  output logic [ADDR_W-1:0] memAddr,
  output logic [XLEN-1:0]   memWdata,
  output logic [REG_W-1:0]  rfRaddr,
  output logic              rfWe,
  output logic [REG_W-1:0]  rfWaddr,
  output logic [XLEN-1:0]   rfWdata
);

  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] DBL_STEP  = ADDR_W'(8);

  logic [ADDR_W-1:0] addrQ;
  logic              loadQ, dblQ;
  logic [3:0]        tblCntQ;
  logic [REG_W-1:0]  regIdx;
  logic [XLEN-1:0]   loadExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      loadQ   <= 1'b0;
      dblQ    <= 1'b0;
      tblCntQ <= '0;
    end else if (strb.capture) begin
      addrQ   <= cmdBase;
      loadQ   <= cmdLoad;
      dblQ    <= cmdDouble;
      tblCntQ <= tableCount(cmdList);
    end else if (strb.step) begin
      addrQ   <= addrQ + (dblQ ? DBL_STEP : WORD_STEP);
    end
  end

  // table entries first, link register after them
  always_comb begin
    if (4'(slot) < tblCntQ) regIdx = tableReg(4'(slot));
    else                     regIdx = REG_W'(LINK_REG);
  end

  generate
    if (XLEN > 32) begin : g_wide
      assign loadExt = dblQ ? memRdata : {{(XLEN-32){memRdata[31]}}, memRdata[31:0]};
    end else begin : g_narrow
      assign loadExt = memRdata;
    end
  endgenerate

  assign modeLoad = loadQ;
  assign memWrite = !loadQ;
  assign memSize  = dblQ;
  assign memAddr  = addrQ;
  assign memWdata = rfRdata;
  assign rfRaddr  = regIdx;
  assign rfWe     = strb.wrback;
  assign rfWaddr  = regIdx;
  assign rfWdata  = loadExt;

endmodule

// File: rtl/lsm_sequencer.sv
module lsm_sequencer
  import lsm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int XLEN   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdLoad,
  input  logic              cmdDouble,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic [4:0]        cmdList,
  output logic              busy,
  output logic              done,
  output logic              memReq,
  output logic              memWrite,
  output logic              memSize,
  output logic [ADDR_W-1:0] memAddr,
  output logic [XLEN-1:0]   memWdata,
  input  logic              memReady,
  input  logic              memRvalid,
  input  logic [XLEN-1:0]   memRdata,
  output logic [4:0]        rfRaddr,
  input  logic [XLEN-1:0]   rfRdata,
  output logic              rfWe,
  output logic [4:0]        rfWaddr,
  output logic [XLEN-1:0]   rfWdata
);

  localparam int CNT_W = $clog2(TBL_LEN + 2);

  seqStrobe_t       strb;
  logic [CNT_W-1:0] slot;
  logic             modeLoad;

  lsm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdList(cmdList),
    .memReady(memReady), .memRvalid(memRvalid), .modeLoad(modeLoad),
    .busy(busy), .done(done), .memReq(memReq), .slot(slot), .strb(strb)
  );

  lsm_datapath #(.ADDR_W(ADDR_W), .XLEN(XLEN), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .slot(slot),
    .cmdLoad(cmdLoad), .cmdDouble(cmdDouble), .cmdBase(cmdBase), .cmdList(cmdList),
    .memRdata(memRdata), .rfRdata(rfRdata), .modeLoad(modeLoad),
    .memWrite(memWrite), .memSize(memSize), .memAddr(memAddr), .memWdata(memWdata),
    .rfRaddr(rfRaddr), .rfWe(rfWe), .rfWaddr(rfWaddr), .rfWdata(rfWdata)
  );

endmodule

// File: rtl/lsm_sequencer_chk.sv
module lsm_sequencer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              memReq,
  input logic              memReady,
  input logic              memWrite,
  input logic              memSize,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRvalid,
  input logic              rfWe,
  input logic [4:0]        rfWaddr
);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWrite)));

  // R7
  req_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady && memWrite) |=>
      (!memReq || memAddr == ADDR_W'($past(memAddr) + ($past(memSize) ? 8 : 4))));

  // R5
  wb_after_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    rfWe |-> (memRvalid && !memReq));

  // R3
  wb_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    rfWe |-> ((rfWaddr >= 5'd16 && rfWaddr <= 5'd23) || rfWaddr == 5'd30 || rfWaddr == 5'd31));

endmodule

bind lsm_sequencer lsm_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .memReq(memReq),
  .memReady(memReady), .memWrite(memWrite), .memSize(memSize), .memAddr(memAddr),
  .memRvalid(memRvalid), .rfWe(rfWe), .rfWaddr(rfWaddr)
);

// File: tb/lsm_sequencer_bench.sv
module lsm_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int XW = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0, cmdLoad = 1'b0, cmdDouble = 1'b0;
  logic [AW-1:0] cmdBase = '0;
  logic [4:0]    cmdList = '0;
  logic          busy, done, memReq, memWrite, memSize;
  logic [AW-1:0] memAddr;
  logic [XW-1:0] memWdata, memRdata = '0, rfRdata, rfWdata;
  logic          memReady = 1'b0, memRvalid = 1'b0, rfWe;
  logic [4:0]    rfRaddr, rfWaddr;
  logic [15:0]   lfsr = 16'hACE1;
  int            checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [XW-1:0] rfVal(input logic [4:0] r);
    return {8'hA0, 19'h0, r, 8'h5B, 19'h0, r};
  endfunction

  function automatic logic [XW-1:0] memVal(input logic [AW-1:0] a);
    return {a ^ 32'h0F0F_1234, a[2] ? (a ^ 32'h8000_0055) : (a ^ 32'h0000_0AA0)};
  endfunction

  function automatic logic [4:0] expReg(input logic [4:0] lst, input int k);
    int n;
    n = (lst[3:0] >= 4'd1 && lst[3:0] <= 4'd9) ? int'(lst[3:0]) : 0;
    if (k < n) return (k < 8) ? 5'(16 + k) : 5'd30;
    return 5'd31;
  endfunction

  assign rfRdata = rfVal(rfRaddr);

  lsm_sequencer #(.ADDR_W(AW), .XLEN(XW)) u_lsm_sequencer (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdLoad(cmdLoad),
    .cmdDouble(cmdDouble), .cmdBase(cmdBase), .cmdList(cmdList),
    .busy(busy), .done(done), .memReq(memReq), .memWrite(memWrite),
    .memSize(memSize), .memAddr(memAddr), .memWdata(memWdata),
    .memReady(memReady), .memRvalid(memRvalid), .memRdata(memRdata),
    .rfRaddr(rfRaddr), .rfRdata(rfRdata), .rfWe(rfWe), .rfWaddr(rfWaddr),
    .rfWdata(rfWdata)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runCmd(input bit ld, input bit dbl, input logic [4:0] lst, input logic [AW-1:0] base);
    int nTbl, total, idx, wbIdx, iter, doneCnt, doneIter;
    bit pend;
    logic [AW-1:0] pendAddr, eAddr;
    logic [4:0] r;
    logic [XW-1:0] e;
    nTbl = (lst[3:0] >= 4'd1 && lst[3:0] <= 4'd9) ? int'(lst[3:0]) : 0;
    total = nTbl + int'(lst[4]);
    idx = 0; wbIdx = 0; iter = 0; doneCnt = 0; doneIter = -1; pend = 0; pendAddr = '0;
    @(negedge clk);
    check(!busy, "R9 idle before command", 64'(busy), 64'd0);
    cmdValid = 1'b1; cmdLoad = ld; cmdDouble = dbl; cmdList = lst; cmdBase = base;
    while (iter < 300 && !(doneIter >= 0 && iter >= doneIter + 2)) begin
      @(negedge clk);
      iter++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      memReady = 1'b0; memRvalid = 1'b0; cmdValid = 1'b0;
      if (iter == 2 && busy) begin  // R9 competing command mid-sequence
        cmdValid = 1'b1; cmdList = 5'h1F; cmdBase = 32'hFFFF_0000; cmdLoad = !ld;
      end
      if (done) begin
        doneCnt++;
        if (doneIter < 0) doneIter = iter;
      end
      if (pend) begin
        if (lfsr[2]) begin
          memRvalid = 1'b1; memRdata = memVal(pendAddr);
          #1;
          r = expReg(lst, wbIdx);
          e = dbl ? memRdata : {{32{memRdata[31]}}, memRdata[31:0]};
          check(rfWe, "R5 write enable with data", 64'(rfWe), 64'd1);
          check(rfWaddr == r, "R5 write register", 64'(rfWaddr), 64'(r));
          check(rfWdata == e, "R5 load data extension", rfWdata, e);
          pend = 0; wbIdx++;
        end else begin
          check(!memReq, "R7 no request while load pending", 64'(memReq), 64'd0);
        end
      end else if (memReq) begin
        if (lfsr[0] | lfsr[1]) begin
          memReady = 1'b1;
          #1;
          if (idx >= total) begin
            check(1'b0, "R1 R3 R9 extra transfer", 64'(idx), 64'(total));
          end else begin
            r = expReg(lst, idx);
            eAddr = base + AW'(idx * (dbl ? 8 : 4));
            check(memAddr == eAddr, "R4 transfer address", 64'(memAddr), 64'(eAddr));
            check(memSize == dbl, "R4 access size", 64'(memSize), 64'(dbl));
            check(memWrite == !ld, "R6 direction", 64'(memWrite), 64'(!ld));
            if (!ld) begin
              check(rfRaddr == r, "R6 store register order", 64'(rfRaddr), 64'(r));
              check(memWdata == rfVal(r), "R6 store data", memWdata, rfVal(r));
            end else begin
              pend = 1; pendAddr = memAddr;
            end
          end
          idx++;
        end
      end
    end
    check(idx == total, "R1 R2 R3 transfer count", 64'(idx), 64'(total));
    check(wbIdx == (ld ? total : 0), "R5 register writes", 64'(wbIdx), 64'(ld ? total : 0));
    check(doneCnt == 1, "R8 single done pulse", 64'(doneCnt), 64'd1);
    if (total == 0)
      check(doneIter == 1, "R2 R8 empty command done at once", 64'(doneIter), 64'd1);
    check(!busy, "R9 idle after done", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(!busy && !done && !memReq && !rfWe, "R10 reset state",
          64'({busy, done, memReq, rfWe}), 64'd0);
    rstN = 1'b1;
    for (int ld = 0; ld < 2; ld++)
      for (int dbl = 0; dbl < 2; dbl++)
        for (int lst = 0; lst < 32; lst++)
          runCmd(ld[0], dbl[0], 5'(lst),
                 32'h0000_1000 + 32'(lst * 128) + ((dbl == 0 && lst[0]) ? 32'd4 : 32'd0));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule